// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a processor's store path and a slower memory bus. It accepts single-word writes and queues them in up to eight line entries. Each entry covers one 16-byte-aligned region and has sixteen data bytes, one written flag per byte, and two separate region tags. The virtual tag is used to decide whether a new write can be folded into an entry. The physical tag is the address sent out on the bus.

A new write is folded into the most recently queued entry when its virtual region matches that entry. Otherwise it takes a fresh entry. The oldest entry is always offered on the memory port and stays there until the port accepts it. Once an entry is offered it is frozen and takes no more merges.

Some writes skip the queue: unbufferable writes, and all writes while the buffer is switched off. These wait until the queue is empty and then go straight to the port. A read that missed the cache is checked against the queued physical regions and is held off while any of them matches. A drain request is held off until the queue is empty.

Top module: `merging_write_buffer`

## Requirements
- R1: After reset the buffer is empty. `mem_valid` is low, `drain_wait` is low even with `drain_req` high, and `rd_stall` is low for any address.
- R2: A queued write lands in byte lane `4*wr_vaddr[3:2] + k` for byte `k` of `wr_data`. The entry is sent with `mem_addr` equal to `wr_paddr` with bits [3:0] cleared.
- R3: A buffered write whose `wr_vaddr[31:4]` equals the newest entry's virtual region is merged into that entry, provided the newest entry is not the oldest one. Merged bytes overwrite older bytes in the same lane, and the byte flags are ORed together.
- R4: A write never merges into an entry older than the newest one. It also never merges into the entry currently offered on the memory port, so a write arriving while only one entry is queued takes a new entry.
- R5: Entries leave in arrival order, one per cycle in which `mem_ready` is high while `mem_valid` is high. While the port is stalled, `mem_addr`, `mem_data` and `mem_strb` stay unchanged.
- R6: With eight entries queued, a buffered write that cannot merge sees `wr_ready` low. It is accepted in the cycle after an entry leaves.
- R7: A write with `wr_bufferable` low sees `wr_ready` low while any entry is queued. When the queue is empty it appears on the port in the same cycle, and `wr_ready` follows `mem_ready`.
- R8: With `buf_enable` low, every write behaves as an unbufferable write.
- R9: `rd_stall` is high exactly when `rd_check` is high and `rd_paddr[31:4]` equals the physical region of some queued entry.
- R10: `drain_wait` is high exactly when `drain_req` is high and at least one entry is queued.
- R11: `mem_strb` bit `b` is set only for byte lanes that a write held in the outgoing entry, or the passing write, actually wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_enable | input | 1 | Buffer on; when low all writes pass through |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_bufferable | input | 1 | Write may be queued |
| wr_vaddr | input | 32 | Virtual word address, used for merging and lane select |
| wr_paddr | input | 32 | Physical address, used for the bus |
| wr_data | input | 32 | Write word |
| wr_strb | input | 4 | Byte enables of the word |
| rd_check | input | 1 | Read miss probe valid |
| rd_paddr | input | 32 | Physical address of the read miss |
| rd_stall | output | 1 | Read must wait; region queued |
| drain_req | input | 1 | Request to empty the buffer |
| drain_wait | output | 1 | Drain not yet complete |
| mem_valid | output | 1 | Memory write offered |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_addr | output | 32 | 16-byte-aligned physical address |
| mem_data | output | 128 | Line data |
| mem_strb | output | 16 | Byte enables of the line |

## Verification
`wr_ready`, `rd_stall`, `drain_wait` and the pass-through contents of the memory port are combinational. They are due in the same cycle as the inputs that cause them. A queued or merged write, and the removal of an accepted entry, become visible on the port only after the next rising edge. The bench drives inputs on the falling edge and samples 1 ns later. Its queue model is updated right after each rising edge, so each expected value is compared in the cycle in which it is due. The model captures pops and pushes in the same cycle and in the right order.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // Which source feeds the memory write port this cycle.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_QUEUE = 2'd1,
    SRC_PASS  = 2'd2
  } wbuf_src_e;
endpackage

// File: rtl/wbuf_store.sv
// Entry storage: per entry a virtual tag, a physical tag, line data and byte flags.
module wbuf_store #(
  parameter int DEPTH      = 8,
  parameter int TAGW       = 28,
  parameter int LINE_BYTES = 16,
  localparam int PW        = $clog2(DEPTH),
  localparam int LBITS     = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_new,
  input  logic [PW-1:0]         wr_idx,
  input  logic [TAGW-1:0]       wr_vtag,
  input  logic [TAGW-1:0]       wr_ptag,
  input  logic [LBITS-1:0]      wr_line,
  input  logic [LINE_BYTES-1:0] wr_flags,
  input  logic [PW-1:0]         head_idx,
  input  logic [PW-1:0]         newest_idx,
  output logic [LBITS-1:0]      head_line,
  output logic [LINE_BYTES-1:0] head_flags,
  output logic [TAGW-1:0]       head_ptag,
  output logic [TAGW-1:0]       newest_vtag,
  output logic [DEPTH*TAGW-1:0] ptag_all
);
  logic [TAGW-1:0]       vtag_arr  [DEPTH];
  logic [TAGW-1:0]       ptag_arr  [DEPTH];
  logic [LBITS-1:0]      line_arr  [DEPTH];
  logic [LINE_BYTES-1:0] flags_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic                  sel;
    logic [TAGW-1:0]       vtag_q, vtag_d, ptag_q, ptag_d;
    logic [LBITS-1:0]      line_q, line_d;
    logic [LINE_BYTES-1:0] flags_q, flags_d;

    assign sel = wr_en && (wr_idx == PW'(i));

    always_comb begin
      vtag_d  = vtag_q;
      ptag_d  = ptag_q;
      line_d  = line_q;
      flags_d = flags_q;
      if (wr_new) begin
        vtag_d  = wr_vtag;
        ptag_d  = wr_ptag;
        line_d  = wr_line;
        flags_d = wr_flags;
      end else begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (wr_flags[b]) line_d[b*8 +: 8] = wr_line[b*8 +: 8];
        end
        flags_d = flags_q | wr_flags;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vtag_q  <= '0;
        ptag_q  <= '0;
        line_q  <= '0;
        flags_q <= '0;
      end else if (sel) begin
        vtag_q  <= vtag_d;
        ptag_q  <= ptag_d;
        line_q  <= line_d;
        flags_q <= flags_d;
      end
    end

    assign vtag_arr[i]               = vtag_q;
    assign ptag_arr[i]               = ptag_q;
    assign line_arr[i]               = line_q;
    assign flags_arr[i]              = flags_q;
    assign ptag_all[i*TAGW +: TAGW]  = ptag_q;
  end

  assign head_line   = line_arr[head_idx];
  assign head_flags  = flags_arr[head_idx];
  assign head_ptag   = ptag_arr[head_idx];
  assign newest_vtag = vtag_arr[newest_idx];
endmodule

// File: rtl/wbuf_match.sv
// Compares a read-miss region against the physical tag of every occupied entry.
module wbuf_match #(
  parameter int DEPTH = 8,
  parameter int TAGW  = 28,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH*TAGW-1:0] ptag_all,
  input  logic [PW-1:0]         head_idx,
  input  logic [PW:0]           count,
  input  logic                  probe_en,
  input  logic [TAGW-1:0]       probe_tag,
  output logic                  hit
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [PW-1:0] rel;
    assign rel        = PW'(i) - head_idx;
    assign hit_vec[i] = ({1'b0, rel} < count) && (ptag_all[i*TAGW +: TAGW] == probe_tag);
  end

  assign hit = probe_en && (|hit_vec);
endmodule

// File: rtl/merging_write_buffer.sv
// DEPTH must be a power of two (pointer wrap by truncation).
module merging_write_buffer #(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  localparam int LBITS     = LINE_BYTES * 8,
  localparam int WBITS     = WORD_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  buf_enable,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic                  wr_bufferable,
  input  logic [AW-1:0]         wr_vaddr,
  input  logic [AW-1:0]         wr_paddr,
  input  logic [WBITS-1:0]      wr_data,
  input  logic [WORD_BYTES-1:0] wr_strb,
  input  logic                  rd_check,
  input  logic [AW-1:0]         rd_paddr,
  output logic                  rd_stall,
  input  logic                  drain_req,
  output logic                  drain_wait,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [AW-1:0]         mem_addr,
  output logic [LBITS-1:0]      mem_data,
  output logic [LINE_BYTES-1:0] mem_strb
);
  import wbuf_pkg::*;

  localparam int OFS   = $clog2(LINE_BYTES);
  localparam int WOFS  = $clog2(WORD_BYTES);
  localparam int LANES = LINE_BYTES / WORD_BYTES;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int TAGW  = AW - OFS;
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = PW + 1;

  // Queue pointers and occupancy
  logic [CW-1:0] count_q, count_d;
  logic [PW-1:0] head_q, head_d, tail_q, tail_d, newest_idx;

  // Incoming write placed in its line lane
  logic [LW-1:0]         lane;
  logic [LBITS-1:0]      line_in;
  logic [LINE_BYTES-1:0] flags_in;

  logic buffered, q_empty, newest_open, merge_hit, alloc_ok, pass_ok;
  logic wr_fire, push, merge, pop;
  wbuf_src_e src;

  logic [LBITS-1:0]      head_line;
  logic [LINE_BYTES-1:0] head_flags;
  logic [TAGW-1:0]       head_ptag, newest_vtag;
  logic [DEPTH*TAGW-1:0] ptag_all;

  assign lane = LW'(wr_vaddr[OFS-1:WOFS]);

  always_comb begin
    line_in  = '0;
    flags_in = '0;
    line_in[lane*WBITS +: WBITS]       = wr_data;
    flags_in[lane*WORD_BYTES +: WORD_BYTES] = wr_strb;
  end

  // Write acceptance
  assign newest_idx  = tail_q - PW'(1);
  assign buffered    = buf_enable && wr_bufferable;
  assign q_empty     = (count_q == '0);
  assign newest_open = (count_q > CW'(1));
  assign merge_hit   = buffered && newest_open && (newest_vtag == wr_vaddr[AW-1:OFS]);
  assign alloc_ok    = buffered && !merge_hit && (count_q < CW'(DEPTH));
  assign pass_ok     = !buffered && q_empty;
  assign wr_ready    = merge_hit || alloc_ok || (pass_ok && mem_ready);
  assign wr_fire     = wr_valid && wr_ready;
  assign push        = wr_fire && alloc_ok;
  assign merge       = wr_fire && merge_hit;
  assign pop         = !q_empty && mem_ready;

  // Memory port source select
  always_comb begin
    src = SRC_NONE;
    if (!q_empty)                    src = SRC_QUEUE;
    else if (wr_valid && !buffered)  src = SRC_PASS;
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_addr  = '0;
    mem_data  = '0;
    mem_strb  = '0;
    unique case (src)
      SRC_QUEUE: begin
        mem_valid = 1'b1;
        mem_addr  = {head_ptag, {OFS{1'b0}}};
        mem_data  = head_line;
        mem_strb  = head_flags;
      end
      SRC_PASS: begin
        mem_valid = 1'b1;
        mem_addr  = {wr_paddr[AW-1:OFS], {OFS{1'b0}}};
        mem_data  = line_in;
        mem_strb  = flags_in;
      end
      default: ;
    endcase
  end

  assign drain_wait = drain_req && !q_empty;

  // Next state
  always_comb begin
    count_d = count_q + CW'(push) - CW'(pop);
    head_d  = pop  ? head_q + PW'(1) : head_q;
    tail_d  = push ? tail_q + PW'(1) : tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else begin
      if (push || pop) count_q <= count_d;
      if (pop)         head_q  <= head_d;
      if (push)        tail_q  <= tail_d;
    end
  end

  wbuf_store #(.DEPTH(DEPTH), .TAGW(TAGW), .LINE_BYTES(LINE_BYTES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (push || merge),
    .wr_new      (push),
    .wr_idx      (push ? tail_q : newest_idx),
    .wr_vtag     (wr_vaddr[AW-1:OFS]),
    .wr_ptag     (wr_paddr[AW-1:OFS]),
    .wr_line     (line_in),
    .wr_flags    (flags_in),
    .head_idx    (head_q),
    .newest_idx  (newest_idx),
    .head_line   (head_line),
    .head_flags  (head_flags),
    .head_ptag   (head_ptag),
    .newest_vtag (newest_vtag),
    .ptag_all    (ptag_all)
  );

  wbuf_match #(.DEPTH(DEPTH), .TAGW(TAGW)) u_match (
    .ptag_all  (ptag_all),
    .head_idx  (head_q),
    .count     (count_q),
    .probe_en  (rd_check),
    .probe_tag (rd_paddr[AW-1:OFS]),
    .hit       (rd_stall)
  );
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 16,
  localparam int CW        = $clog2(DEPTH) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    buf_enable,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic                    wr_bufferable,
  input logic                    rd_check,
  input logic                    rd_stall,
  input logic                    drain_wait,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [AW-1:0]           mem_addr,
  input logic [LINE_BYTES*8-1:0] mem_data,
  input logic [LINE_BYTES-1:0]   mem_strb,
  input logic [CW-1:0]           count_q
);
  // R5 and R4: a stalled queued entry stays frozen on the port
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && count_q != '0) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_strb) && $stable(mem_data)));

  // R6: a write accepted while full must be a merge
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(DEPTH) && wr_valid && wr_ready) |=> (count_q <= $past(count_q)));

  // R7 / R8: a write that bypasses the queue is accepted only when the queue is empty
  a_r7_pass_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(buf_enable && wr_bufferable)) |-> (count_q == '0));

  // R9: a read stall needs a probe and a queued entry
  a_r9_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> (rd_check && count_q != '0));

  // R10: while a drain waits, an entry is on offer
  a_r10_drain_offer: assert property (@(posedge clk) disable iff (!rst_n)
    drain_wait |-> mem_valid);
endmodule

bind merging_write_buffer wbuf_checker #(
  .DEPTH(DEPTH), .AW(AW), .LINE_BYTES(LINE_BYTES)
) u_wbuf_chk (
  .clk(clk), .rst_n(rst_n), .buf_enable(buf_enable), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_bufferable(wr_bufferable), .rd_check(rd_check),
  .rd_stall(rd_stall), .drain_wait(drain_wait), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_strb(mem_strb), .count_q(count_q)
);

// File: tb/tb_merging_write_buffer.sv
module tb_merging_write_buffer;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_enable = 1'b1, wr_valid = 1'b0, wr_bufferable = 1'b1;
  logic [31:0] wr_vaddr = '0, wr_paddr = '0, wr_data = '0, rd_paddr = '0;
  logic [3:0]  wr_strb = '0;
  logic rd_check = 1'b0, drain_req = 1'b0, mem_ready = 1'b0;
  logic wr_ready, rd_stall, drain_wait, mem_valid;
  logic [31:0]  mem_addr;
  logic [127:0] mem_data;
  logic [15:0]  mem_strb;

  always #10 clk = ~clk;

  merging_write_buffer dut (
    .clk(clk), .rst_n(rst_n), .buf_enable(buf_enable), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_bufferable(wr_bufferable), .wr_vaddr(wr_vaddr),
    .wr_paddr(wr_paddr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_check(rd_check), .rd_paddr(rd_paddr), .rd_stall(rd_stall),
    .drain_req(drain_req), .drain_wait(drain_wait), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_strb(mem_strb)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit last_fire;

  // Reference queue, index 0 is the oldest entry
  logic [27:0]  qv [DEPTH];
  logic [27:0]  qp [DEPTH];
  logic [127:0] qd [DEPTH];
  logic [15:0]  qb [DEPTH];
  int qn = 0;

  function automatic logic [127:0] xdata(input logic [31:0] a, input logic [31:0] d);
    return {96'd0, d} << (32 * int'(a[3:2]));
  endfunction
  function automatic logic [15:0] xstrb(input logic [31:0] a, input logic [3:0] s);
    return {12'd0, s} << (4 * int'(a[3:2]));
  endfunction
  function automatic logic [127:0] bmask(input logic [15:0] s);
    logic [127:0] m = '0;
    for (int b = 0; b < 16; b++) m[b*8 +: 8] = {8{s[b]}};
    return m;
  endfunction
  function automatic logic [31:0] v2p(input logic [31:0] v);
    return v ^ 32'h4000_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: inputs already driven after a falling edge.
  task automatic step();
    bit bf, mg, al, ps, fire, pop, hit;
    logic [127:0] m;
    bf = buf_enable && wr_bufferable;
    mg = bf && qn >= 2 && qv[qn-1] == wr_vaddr[31:4];
    al = bf && !mg && qn < DEPTH;
    ps = !bf && qn == 0;
    #1;
    chk(mem_valid == (qn > 0 || (wr_valid && !bf)), "R5", "mem_valid", 128'(mem_valid),
        128'(qn > 0 || (wr_valid && !bf)));
    if (qn > 0) begin
      m = bmask(qb[0]);
      chk(mem_addr == {qp[0], 4'h0}, "R5", "mem_addr", 128'(mem_addr), 128'({qp[0], 4'h0}));
      chk(mem_strb == qb[0], "R11", "mem_strb", 128'(mem_strb), 128'(qb[0]));
      chk((mem_data & m) == (qd[0] & m), "R2", "mem_data", mem_data & m, qd[0] & m);
    end else if (wr_valid && !bf) begin
      m = bmask(xstrb(wr_vaddr, wr_strb));
      chk(mem_addr == {wr_paddr[31:4], 4'h0}, "R7", "pass addr", 128'(mem_addr),
          128'({wr_paddr[31:4], 4'h0}));
      chk(mem_strb == xstrb(wr_vaddr, wr_strb), "R11", "pass strb", 128'(mem_strb),
          128'(xstrb(wr_vaddr, wr_strb)));
      chk((mem_data & m) == (xdata(wr_vaddr, wr_data) & m), "R7", "pass data",
          mem_data & m, xdata(wr_vaddr, wr_data) & m);
    end
    if (wr_valid)
      chk(wr_ready == (mg || al || (ps && mem_ready)), "R6", "wr_ready", 128'(wr_ready),
          128'(mg || al || (ps && mem_ready)));
    hit = 1'b0;
    for (int i = 0; i < qn; i++) if (qp[i] == rd_paddr[31:4]) hit = 1'b1;
    chk(rd_stall == (rd_check && hit), "R9", "rd_stall", 128'(rd_stall), 128'(rd_check && hit));
    chk(drain_wait == (drain_req && qn > 0), "R10", "drain_wait", 128'(drain_wait),
        128'(drain_req && qn > 0));
    fire = wr_valid && (mg || al || (ps && mem_ready));
    pop  = qn > 0 && mem_ready;
    last_fire = fire;
    @(posedge clk);
    if (fire && mg) begin
      for (int b = 0; b < 16; b++)
        if (xstrb(wr_vaddr, wr_strb)[b]) qd[qn-1][b*8 +: 8] = xdata(wr_vaddr, wr_data)[b*8 +: 8];
      qb[qn-1] = qb[qn-1] | xstrb(wr_vaddr, wr_strb);
    end else if (fire && al) begin
      qv[qn] = wr_vaddr[31:4];
      qp[qn] = wr_paddr[31:4];
      qd[qn] = xdata(wr_vaddr, wr_data);
      qb[qn] = xstrb(wr_vaddr, wr_strb);
      qn++;
    end
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        qv[i] = qv[i+1]; qp[i] = qp[i+1]; qd[i] = qd[i+1]; qb[i] = qb[i+1];
      end
      qn--;
    end
    @(negedge clk);
  endtask

  task automatic put(input logic [31:0] va, input logic [31:0] d, input logic [3:0] s,
                     input logic bufb);
    wr_valid = 1'b1; wr_vaddr = va; wr_paddr = v2p(va); wr_data = d; wr_strb = s;
    wr_bufferable = bufb;
    for (int k = 0; k < 40; k++) begin
      step();
      if (last_fire) break;
    end
    wr_valid = 1'b0;
  endtask

  task automatic peek(input string req, input logic [31:0] ea, input logic [15:0] es);
    #1;
    chk(mem_valid == 1'b1, req, "peek valid", 128'(mem_valid), 128'(1));
    chk(mem_addr == ea, req, "peek addr", 128'(mem_addr), 128'(ea));
    chk(mem_strb == es, req, "peek strb", 128'(mem_strb), 128'(es));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R5", "watchdog expired", 128'(0), 128'(1));
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    drain_req = 1'b1; rd_check = 1'b1; rd_paddr = 32'h4000_1000;
    #1;
    chk(mem_valid == 1'b0, "R1", "mem_valid after reset", 128'(mem_valid), 128'(0));
    chk(drain_wait == 1'b0, "R1", "drain_wait after reset", 128'(drain_wait), 128'(0));
    chk(rd_stall == 1'b0, "R1", "rd_stall after reset", 128'(rd_stall), 128'(0));
    drain_req = 1'b0; rd_check = 1'b0;
    @(negedge clk);

    // R2 R3 R4: allocation and newest-only merge with the port stalled
    mem_ready = 1'b0;
    put(32'h0000_1000, 32'h1111_1111, 4'hF, 1'b1);
    put(32'h0000_1004, 32'h2222_2222, 4'hF, 1'b1);   // head frozen: new entry
    put(32'h0000_1008, 32'h3333_3333, 4'hF, 1'b1);   // merges into newest
    put(32'h0000_2000, 32'h4444_4444, 4'hF, 1'b1);
    put(32'h0000_100C, 32'h5555_5555, 4'hF, 1'b1);   // older match only: new entry
    rd_check = 1'b1; rd_paddr = 32'h4000_2008;
    #1; chk(rd_stall == 1'b1, "R9", "queued region hit", 128'(rd_stall), 128'(1));
    rd_paddr = 32'h4000_3000;
    #1; chk(rd_stall == 1'b0, "R9", "foreign region", 128'(rd_stall), 128'(0));
    rd_check = 1'b0;
    drain_req = 1'b1;
    peek("R2", 32'h4000_1000, 16'h000F);
    mem_ready = 1'b1; step();
    peek("R3", 32'h4000_1000, 16'h0FF0);
    chk(mem_data[95:32] == 64'h3333_3333_2222_2222, "R3", "merged data",
        128'(mem_data[95:32]), 128'(64'h3333_3333_2222_2222));
    step();
    peek("R5", 32'h4000_2000, 16'h000F);
    step();
    peek("R4", 32'h4000_1000, 16'hF000);
    step();
    #1; chk(drain_wait == 1'b0, "R10", "drain complete", 128'(drain_wait), 128'(0));
    drain_req = 1'b0;
    @(negedge clk);

    // R6: full queue stalls a non-merging write
    mem_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) put(32'h0000_3000 + 32'(i * 16), 32'(i), 4'h1, 1'b1);
    wr_valid = 1'b1; wr_vaddr = 32'h0000_3800; wr_paddr = v2p(32'h0000_3800);
    wr_data = 32'hABCD_0001; wr_strb = 4'h3;
    #1; chk(wr_ready == 1'b0, "R6", "full stall", 128'(wr_ready), 128'(0));
    step();
    mem_ready = 1'b1; step();
    mem_ready = 1'b0;
    #1; chk(wr_ready == 1'b1, "R6", "accept after pop", 128'(wr_ready), 128'(1));
    step();
    wr_valid = 1'b0;
    mem_ready = 1'b1;
    for (int k = 0; k < 12; k++) step();

    // R7: unbufferable write waits for empty then passes through
    mem_ready = 1'b0;
    put(32'h0000_4000, 32'h0A0A_0A0A, 4'hF, 1'b1);
    put(32'h0000_4010, 32'h0B0B_0B0B, 4'hF, 1'b1);
    wr_valid = 1'b1; wr_bufferable = 1'b0; wr_vaddr = 32'h0000_5008;
    wr_paddr = v2p(32'h0000_5008); wr_data = 32'hCAFE_F00D; wr_strb = 4'h6;
    #1; chk(wr_ready == 1'b0, "R7", "blocked while queued", 128'(wr_ready), 128'(0));
    mem_ready = 1'b1; step(); step();
    peek("R7", 32'h4000_5000, 16'h0600);
    chk(wr_ready == 1'b1, "R7", "pass accepted", 128'(wr_ready), 128'(1));
    step();
    wr_valid = 1'b0; wr_bufferable = 1'b1;

    // R8: disabled buffer passes bufferable writes straight through
    buf_enable = 1'b0; mem_ready = 1'b0;
    wr_valid = 1'b1; wr_vaddr = 32'h0000_6004; wr_paddr = v2p(32'h0000_6004);
    wr_data = 32'h1234_5678; wr_strb = 4'hF;
    peek("R8", 32'h4000_6000, 16'h00F0);
    chk(wr_ready == 1'b0, "R8", "waits for memory", 128'(wr_ready), 128'(0));
    mem_ready = 1'b1;
    #1; chk(wr_ready == 1'b1, "R8", "passes when ready", 128'(wr_ready), 128'(1));
    step();
    wr_valid = 1'b0; buf_enable = 1'b1;
    @(negedge clk);

    // Random traffic against the reference queue
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] va;
      va = 32'h0000_7000 + 32'(($urandom % 5) * 16) + 32'(($urandom % 4) * 4);
      wr_valid      = ($urandom % 3) != 0;
      wr_vaddr      = va;
      wr_paddr      = v2p(va);
      wr_data       = $urandom;
      wr_strb       = 4'(($urandom % 15) + 1);
      wr_bufferable = ($urandom % 10) != 0;
      buf_enable    = ($urandom % 20) != 0;
      mem_ready     = ($urandom % 3) == 0;
      rd_check      = ($urandom % 2) == 0;
      rd_paddr      = v2p(32'h0000_7000 + 32'(($urandom % 6) * 16));
      drain_req     = ($urandom % 8) == 0;
      step();
    end
    wr_valid = 1'b0; rd_check = 1'b0; buf_enable = 1'b1;
    drain_req = 1'b1; mem_ready = 1'b1;
    for (int k = 0; k < 12; k++) step();
    #1; chk(drain_wait == 1'b0, "R10", "final drain", 128'(drain_wait), 128'(0));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule